// File: doc/BRIEF.md
# Pipelined Sixteen-Bit Mini-ISA Core

This block is a small in-order processor core that runs an eight-opcode instruction set on 16-bit words. It contains a sixteen-entry register file and a 4096-word memory that holds both code and data. The memory has one port for instruction fetch, one for data loads and stores, and one combinational peek port. A testbench fills the memory through an init write port while reset is held. It then releases reset and waits for the core to raise its halt flag.

The core has four stages: fetch address (F), decode and operand read (D), execute (X), and writeback (W). Each memory read returns its data one cycle after the address is presented. Results of `mov` and `add` are forwarded from X and from W back into D. If the instruction in D uses the result of a load that is still in X, D is held for one cycle. Jumps, taken compare-branches, stores and halt are all resolved in X. Any younger instruction already fetched behind them is squashed.

Stores redirect fetch to the instruction after the store. This means a store that rewrites code that has already been fetched still takes effect in program order.

A small control state machine sets whether fetching continues:
- `S_RUN`: instructions are fetched every cycle.
- `S_DRAIN`: entered when halt reaches X. Fetch stops and the halt moves into W.
- `S_HALTED`: entered the cycle after `S_DRAIN` and kept until reset.

The transitions are `S_RUN → S_DRAIN` (halt in X), `S_DRAIN → S_HALTED` (always), and `S_HALTED → S_HALTED`.

Top module: `cpu_core`

## Requirements
- R1: While reset is asserted and on the cycle after release, `halted_o` is 0 and `retired_o` is 0. All sixteen registers start at zero.
- R2: `0000 iiiiiiii tttt` writes the zero-extended 8-bit immediate to register t. `0001 aaaa bbbb tttt` writes regs[a]+regs[b] (16-bit wrap) to register t. A result is usable by the very next instruction.
- R3: `0100 iiiiiiii tttt` loads mem[i] into register t. `0101 aaaa bbbb tttt` loads mem[(regs[a]+regs[b]) mod 4096] into register t. An instruction that uses a loaded value right after the load gets that value.
- R4: `0111 aaaa ssssssss` writes regs[a] to mem[s]. Any later load or instruction fetch of that address, including code already in the pipeline, sees the new word.
- R5: `0010 jjjjjjjjjjjj` continues execution at address j. Instructions that follow the jump in memory are not executed.
- R6: `0110 aaaa bbbb dddd`: if regs[a]==regs[b], execution continues at the branch's own address plus the unsigned d. Otherwise it continues at the next address.
- R7: Exactly 16'h3000 halts. `halted_o` then stays 1, no further instruction retires, and `pc_o` shows the halt's address.
- R8: Opcodes 1000–1111 and words 16'h3001–16'h3FFF change no register or memory word and act as no-ops.
- R9: `retired_o` counts each executed instruction once, the halt included. It never grows by more than one per cycle.
- R10: A load-use hold and a redirect each leave a bubble in X on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_we | input | 1 | Memory preload write enable (use while reset is held) |
| init_addr | input | AW | Preload address |
| init_data | input | 16 | Preload data |
| peek_addr | input | AW | Combinational memory observe address |
| peek_data | output | 16 | Memory word at peek_addr |
| halted_o | output | 1 | Core has halted |
| pc_o | output | AW | Address of the most recently retired instruction |
| retired_o | output | CW | Retired instruction count |

## Verification
The hardest case to reach is a store that overwrites an instruction which has already been fetched. From the ports alone, a stale copy of that instruction cannot be told apart from a fresh one unless its effect ends up in memory. The stimulus therefore loads a full instruction word from data memory and stores it two words ahead of the store, over an original halt. It then stores a register that only the rewritten instruction sets. Each program's final memory window, retire count and PC are compared with an in-bench sequential interpreter of the instruction set.

// File: rtl/cpu_pkg.sv
package cpu_pkg;
    localparam int WORD_W = 16;
    localparam int NREG   = 16;
    localparam int RIDX_W = $clog2(NREG);

    localparam logic [3:0] OPC_MOV = 4'h0;
    localparam logic [3:0] OPC_ADD = 4'h1;
    localparam logic [3:0] OPC_JMP = 4'h2;
    localparam logic [3:0] OPC_LD  = 4'h4;
    localparam logic [3:0] OPC_LDR = 4'h5;
    localparam logic [3:0] OPC_JEQ = 4'h6;
    localparam logic [3:0] OPC_ST  = 4'h7;
    localparam logic [WORD_W-1:0] HALT_WORD = 16'h3000;

    typedef enum logic [1:0] {
        S_RUN,
        S_DRAIN,
        S_HALTED
    } run_state_e;
endpackage

// File: rtl/cpu_mem.sv
module cpu_mem #(
    parameter int AW = 12,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic [AW-1:0] f_addr,
    output logic [DW-1:0] f_data,
    input  logic [AW-1:0] d_addr,
    output logic [DW-1:0] d_data,
    input  logic          we,
    input  logic [AW-1:0] w_addr,
    input  logic [DW-1:0] w_data,
    input  logic [AW-1:0] p_addr,
    output logic [DW-1:0] p_data
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] ram [DEPTH];

    // write-first on both read ports: a same-edge store is visible at once
    always_ff @(posedge clk) begin
        if (we) ram[w_addr] <= w_data;
        f_data <= (we && w_addr == f_addr) ? w_data : ram[f_addr];
        d_data <= (we && w_addr == d_addr) ? w_data : ram[d_addr];
    end

    assign p_data = ram[p_addr];
endmodule

// File: rtl/cpu_regfile.sv
module cpu_regfile #(
    parameter int NR = 16,
    parameter int DW = 16,
    localparam int IW = $clog2(NR)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [IW-1:0] ra,
    input  logic [IW-1:0] rb,
    output logic [DW-1:0] qa,
    output logic [DW-1:0] qb,
    input  logic          we,
    input  logic [IW-1:0] wa,
    input  logic [DW-1:0] wd
);
    logic [DW-1:0] rf [NR];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NR; i++) rf[i] <= '0;
        end else if (we) begin
            rf[wa] <= wd;
        end
    end

    assign qa = rf[ra];
    assign qb = rf[rb];
endmodule

// File: rtl/cpu_ctrl.sv
module cpu_ctrl
    import cpu_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic halt_in_x,
    output logic fetch_en,
    output logic halted
);
    run_state_e state, state_nx;

    always_ff @(posedge clk) begin
        if (rst) state <= S_RUN;
        else     state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        fetch_en = 1'b0;
        halted   = 1'b0;
        unique case (state)
            S_RUN: begin
                fetch_en = !halt_in_x;
                if (halt_in_x) state_nx = S_DRAIN;
            end
            S_DRAIN: begin
                state_nx = S_HALTED;
            end
            S_HALTED: begin
                halted = 1'b1;
            end
            default: state_nx = S_RUN;
        endcase
    end
endmodule

// File: rtl/cpu_core.sv
module cpu_core
    import cpu_pkg::*;
#(
    parameter int AW = 12,
    parameter int CW = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              init_we,
    input  logic [AW-1:0]     init_addr,
    input  logic [WORD_W-1:0] init_data,
    input  logic [AW-1:0]     peek_addr,
    output logic [WORD_W-1:0] peek_data,
    output logic              halted_o,
    output logic [AW-1:0]     pc_o,
    output logic [CW-1:0]     retired_o
);
    localparam int DW = WORD_W;
    localparam int IW = RIDX_W;

    // ---- pipeline state ----
    logic [AW-1:0] pc_f;
    logic          d_v;
    logic [AW-1:0] d_pc;
    logic          x_v;
    logic [AW-1:0] x_pc;
    logic [DW-1:0] x_inst, x_av, x_bv;
    logic          w_v, w_wr, w_load;
    logic [IW-1:0] w_t;
    logic [DW-1:0] w_res;
    logic [AW-1:0] w_pc;

    logic [DW-1:0] f_word, ld_word, rf_a, rf_b, fwd_a, fwd_b, w_val, x_res;
    logic [AW-1:0] f_addr, dm_addr, redir_tgt, m_waddr;
    logic [DW-1:0] m_wdata;
    logic          m_we, fetch_en, halt_in_x, redirect, ld_stall;

    // ---- decode in D ----
    logic [3:0]    d_op;
    logic [IW-1:0] d_a, d_b;
    logic          use_a, use_b;
    assign d_op  = f_word[15:12];
    assign d_a   = f_word[11:8];
    assign d_b   = f_word[7:4];
    assign use_a = d_op inside {OPC_ADD, OPC_LDR, OPC_JEQ, OPC_ST};
    assign use_b = d_op inside {OPC_ADD, OPC_LDR, OPC_JEQ};

    // ---- execute in X ----
    logic [3:0]    x_op;
    logic [IW-1:0] x_t;
    logic          x_wr, x_load, x_store;
    logic [DW-1:0] x_sum;
    assign x_op    = x_inst[15:12];
    assign x_t     = x_inst[3:0];
    assign x_sum   = x_av + x_bv;
    assign x_wr    = x_v && (x_op inside {OPC_MOV, OPC_ADD, OPC_LD, OPC_LDR});
    assign x_load  = x_v && (x_op inside {OPC_LD, OPC_LDR});
    assign x_store = x_v && x_op == OPC_ST;
    assign x_res   = (x_op == OPC_MOV) ? DW'(x_inst[11:4]) : x_sum;
    assign halt_in_x = x_v && x_inst == HALT_WORD;
    assign dm_addr = (x_op == OPC_LD) ? AW'(x_inst[11:4]) : x_sum[AW-1:0];

    always_comb begin
        redirect  = 1'b0;
        redir_tgt = x_pc + AW'(1);
        if (x_v) begin
            unique case (x_op)
                OPC_JMP: begin redirect = 1'b1; redir_tgt = x_inst[AW-1:0]; end
                OPC_JEQ: begin
                    redirect  = (x_av == x_bv);
                    redir_tgt = x_pc + AW'(x_inst[3:0]);
                end
                OPC_ST:  redirect = 1'b1;   // refetch after a possible code rewrite
                default: redirect = 1'b0;
            endcase
        end
    end

    // ---- forwarding and load-use hold ----
    assign w_val = w_load ? ld_word : w_res;

    always_comb begin
        fwd_a = rf_a;
        if (w_v && w_wr && w_t == d_a) fwd_a = w_val;
        if (x_wr && !x_load && x_t == d_a) fwd_a = x_res;
    end

    always_comb begin
        fwd_b = rf_b;
        if (w_v && w_wr && w_t == d_b) fwd_b = w_val;
        if (x_wr && !x_load && x_t == d_b) fwd_b = x_res;
    end

    assign ld_stall = d_v && x_load &&
                      ((use_a && d_a == x_t) || (use_b && d_b == x_t));

    assign f_addr = redirect ? redir_tgt : (ld_stall ? d_pc : pc_f);

    // ---- memory write arbitration ----
    assign m_we    = x_store || init_we;
    assign m_waddr = x_store ? AW'(x_inst[7:0]) : init_addr;
    assign m_wdata = x_store ? x_av : init_data;

    cpu_mem #(.AW(AW), .DW(DW)) u_mem (
        .clk(clk), .f_addr(f_addr), .f_data(f_word),
        .d_addr(dm_addr), .d_data(ld_word),
        .we(m_we), .w_addr(m_waddr), .w_data(m_wdata),
        .p_addr(peek_addr), .p_data(peek_data)
    );

    cpu_regfile #(.NR(NREG), .DW(DW)) u_rf (
        .clk(clk), .rst(rst), .ra(d_a), .rb(d_b), .qa(rf_a), .qb(rf_b),
        .we(w_v && w_wr), .wa(w_t), .wd(w_val)
    );

    cpu_ctrl u_ctrl (
        .clk(clk), .rst(rst), .halt_in_x(halt_in_x),
        .fetch_en(fetch_en), .halted(halted_o)
    );

    // ---- stage registers ----
    always_ff @(posedge clk) begin
        if (rst) begin
            pc_f      <= '0;
            d_v       <= 1'b0;
            d_pc      <= '0;
            x_v       <= 1'b0;
            x_pc      <= '0;
            x_inst    <= '0;
            x_av      <= '0;
            x_bv      <= '0;
            w_v       <= 1'b0;
            w_wr      <= 1'b0;
            w_load    <= 1'b0;
            w_t       <= '0;
            w_res     <= '0;
            w_pc      <= '0;
            pc_o      <= '0;
            retired_o <= '0;
        end else begin
            if (fetch_en) pc_f <= f_addr + AW'(1);
            d_v    <= fetch_en;
            d_pc   <= f_addr;
            x_v    <= d_v && !ld_stall && !redirect && !halt_in_x;
            x_pc   <= d_pc;
            x_inst <= f_word;
            x_av   <= fwd_a;
            x_bv   <= fwd_b;
            w_v    <= x_v;
            w_wr   <= x_wr;
            w_load <= x_load;
            w_t    <= x_t;
            w_res  <= x_res;
            w_pc   <= x_pc;
            if (w_v) begin
                retired_o <= retired_o + CW'(1);
                pc_o      <= w_pc;
            end
        end
    end
endmodule

// File: rtl/cpu_core_chk.sv
module cpu_core_chk #(
    parameter int CW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          halted,
    input logic [CW-1:0] retired,
    input logic          ld_stall,
    input logic          redirect,
    input logic          x_v,
    input logic          fetch_en
);
    a_r7_halt_sticky: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted);

    a_r7_no_fetch_halted: assert property (@(posedge clk) disable iff (rst)
        halted |-> !fetch_en);

    a_r9_frozen_after_halt: assert property (@(posedge clk) disable iff (rst)
        halted |=> $stable(retired));

    a_r9_one_per_cycle: assert property (@(posedge clk) disable iff (rst)
        (retired - $past(retired)) <= CW'(1));

    a_r10_stall_bubble: assert property (@(posedge clk) disable iff (rst)
        ld_stall |=> !x_v);

    a_r10_redirect_bubble: assert property (@(posedge clk) disable iff (rst)
        redirect |=> !x_v);
endmodule

bind cpu_core cpu_core_chk #(.CW(CW)) u_chk (
    .clk(clk), .rst(rst), .halted(halted_o), .retired(retired_o),
    .ld_stall(ld_stall), .redirect(redirect), .x_v(x_v), .fetch_en(fetch_en)
);

// File: tb/sim_cpu_core.sv
module sim_cpu_core;
    localparam int AW = 12;
    localparam int CW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          init_we = 1'b0;
    logic [AW-1:0] init_addr = '0;
    logic [15:0]   init_data = '0;
    logic [AW-1:0] peek_addr = '0;
    logic [15:0]   peek_data;
    logic          halted_o;
    logic [AW-1:0] pc_o;
    logic [CW-1:0] retired_o;

    int checks = 0;
    int errors = 0;

    logic [15:0] img [256];
    logic [15:0] ref_mem [4096];
    logic [15:0] ref_reg [16];
    int          exp_ret;
    logic [11:0] exp_pc;

    always #10 clk = ~clk;   // 50 MHz

    cpu_core #(.AW(AW), .CW(CW)) u0 (
        .clk(clk), .rst(rst), .init_we(init_we), .init_addr(init_addr),
        .init_data(init_data), .peek_addr(peek_addr), .peek_data(peek_data),
        .halted_o(halted_o), .pc_o(pc_o), .retired_o(retired_o)
    );

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL R7 watchdog: actual running expected halted");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    function automatic logic [15:0] e_mov(input int i, input int t);
        return {4'h0, 8'(i), 4'(t)};
    endfunction
    function automatic logic [15:0] e_add(input int a, input int b, input int t);
        return {4'h1, 4'(a), 4'(b), 4'(t)};
    endfunction
    function automatic logic [15:0] e_jmp(input int j);
        return {4'h2, 12'(j)};
    endfunction
    function automatic logic [15:0] e_ld(input int i, input int t);
        return {4'h4, 8'(i), 4'(t)};
    endfunction
    function automatic logic [15:0] e_ldr(input int a, input int b, input int t);
        return {4'h5, 4'(a), 4'(b), 4'(t)};
    endfunction
    function automatic logic [15:0] e_jeq(input int a, input int b, input int d);
        return {4'h6, 4'(a), 4'(b), 4'(d)};
    endfunction
    function automatic logic [15:0] e_st(input int a, input int s);
        return {4'h7, 4'(a), 8'(s)};
    endfunction
    localparam logic [15:0] E_HALT = 16'h3000;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic clear_img();
        for (int a = 0; a < 256; a++) img[a] = 16'h0000;
    endtask

    // sequential interpreter of the instruction set
    task automatic model();
        logic [11:0] pc;
        logic [15:0] w;
        bit done;
        int steps;
        for (int a = 0; a < 4096; a++) ref_mem[a] = (a < 256) ? img[a] : 16'h0000;
        for (int r = 0; r < 16; r++) ref_reg[r] = 16'h0000;
        pc = '0; done = 0; steps = 0;
        while (!done && steps < 10000) begin
            w = ref_mem[pc];
            steps++;
            case (w[15:12])
                4'h0: begin ref_reg[w[3:0]] = {8'h00, w[11:4]}; pc = pc + 1; end
                4'h1: begin ref_reg[w[3:0]] = ref_reg[w[11:8]] + ref_reg[w[7:4]]; pc = pc + 1; end
                4'h2: pc = w[11:0];
                4'h3: if (w == E_HALT) begin done = 1; exp_pc = pc; end else pc = pc + 1;
                4'h4: begin ref_reg[w[3:0]] = ref_mem[{4'h0, w[11:4]}]; pc = pc + 1; end
                4'h5: begin
                    logic [15:0] s;
                    s = ref_reg[w[11:8]] + ref_reg[w[7:4]];
                    ref_reg[w[3:0]] = ref_mem[s[11:0]];
                    pc = pc + 1;
                end
                4'h6: pc = (ref_reg[w[11:8]] == ref_reg[w[7:4]]) ? pc + 12'(w[3:0]) : pc + 1;
                4'h7: begin ref_mem[{4'h0, w[7:0]}] = ref_reg[w[11:8]]; pc = pc + 1; end
                default: pc = pc + 1;
            endcase
        end
        exp_ret = steps;
    endtask

    task automatic run_prog(input string req);
        int cyc;
        logic [CW-1:0] ret_at_halt;
        model();
        rst = 1'b1;
        for (int a = 0; a < 256; a++) begin
            @(negedge clk);
            init_we = 1'b1; init_addr = AW'(a); init_data = img[a];
        end
        @(negedge clk);
        init_we = 1'b0;
        chk("R1", "halted in reset", 32'(halted_o), 0);
        chk("R1", "retired in reset", retired_o, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "retired after release", retired_o, 0);
        cyc = 0;
        while (!halted_o && cyc < 5000) begin
            @(negedge clk);
            cyc++;
        end
        chk(req, "halted reached", 32'(halted_o), 1);
        chk("R7", "pc at halt", 32'(pc_o), 32'(exp_pc));
        chk("R9", "retired count", retired_o, 32'(exp_ret));
        ret_at_halt = retired_o;
        repeat (8) @(negedge clk);
        chk("R7", "halt holds", 32'(halted_o), 1);
        chk("R7", "no retire after halt", retired_o, ret_at_halt);
        for (int a = 16'h80; a < 16'h90; a++) begin
            peek_addr = AW'(a);
            #1;
            chk(req, $sformatf("mem[%0h]", a), 32'(peek_data), 32'(ref_mem[a]));
        end
        rst = 1'b1;
    endtask

    // R2: back-to-back add/mov dependences through both forwarding paths
    task automatic t_forwarding();
        clear_img();
        img[0] = e_mov(5, 1);
        img[1] = e_mov(7, 2);
        img[2] = e_add(1, 2, 3);
        img[3] = e_add(3, 3, 4);
        img[4] = e_add(4, 3, 5);
        img[5] = e_st(4, 16'h80);
        img[6] = e_st(5, 16'h81);
        img[7] = e_st(3, 16'h82);
        img[8] = E_HALT;
        run_prog("R2");
    endtask

    // R3: ld, ldr, load-use holds, ldr address wrap at 12 bits
    task automatic t_loads();
        clear_img();
        img[8'h90] = 16'h1234;
        img[8'h91] = 16'hFE5C;
        img[0]  = e_ld(16'h90, 1);
        img[1]  = e_add(1, 1, 2);
        img[2]  = e_st(2, 16'h82);
        img[3]  = e_mov(3, 5);
        img[4]  = e_mov(16'h8D, 6);
        img[5]  = e_ldr(5, 6, 7);
        img[6]  = e_st(7, 16'h83);
        img[7]  = e_ld(16'h91, 10);
        img[8]  = e_ldr(1, 10, 11);
        img[9]  = e_st(11, 16'h84);
        img[10] = E_HALT;
        run_prog("R3");
    endtask

    // R5 and R6: jump, taken and not-taken compare, load feeding a compare
    task automatic t_branches();
        clear_img();
        img[8'h90] = 16'h0005;
        img[0]  = e_mov(1, 1);
        img[1]  = e_mov(1, 2);
        img[2]  = e_jeq(1, 2, 3);
        img[3]  = e_mov(16'hEE, 3);
        img[4]  = e_mov(16'hEE, 3);
        img[5]  = e_mov(2, 4);
        img[6]  = e_jeq(1, 4, 4);
        img[7]  = e_jmp(9);
        img[8]  = e_mov(16'hDD, 3);
        img[9]  = e_st(4, 16'h84);
        img[10] = e_st(3, 16'h85);
        img[11] = e_mov(5, 6);
        img[12] = e_ld(16'h90, 5);
        img[13] = e_jeq(5, 6, 2);
        img[14] = e_st(6, 16'h86);
        img[15] = e_st(5, 16'h87);
        img[16] = E_HALT;
        run_prog("R6");
    endtask

    // R4: store then load of same word, and a store rewriting fetched code
    task automatic t_store_alias();
        clear_img();
        img[8'h95] = e_mov(16'h77, 8);
        img[0]  = e_mov(16'h42, 1);
        img[1]  = e_st(1, 16'h86);
        img[2]  = e_ld(16'h86, 2);
        img[3]  = e_add(2, 2, 3);
        img[4]  = e_st(3, 16'h87);
        img[5]  = e_ld(16'h95, 9);
        img[6]  = e_st(9, 16'h08);
        img[7]  = e_mov(1, 10);
        img[8]  = E_HALT;
        img[9]  = e_st(8, 16'h89);
        img[10] = E_HALT;
        run_prog("R4");
    endtask

    // R8: undefined opcodes and non-exact halt words are no-ops
    task automatic t_noops();
        clear_img();
        img[8'h8A] = 16'hFFFF;
        img[0] = 16'h8123;
        img[1] = 16'hF0F1;
        img[2] = 16'h3001;
        img[3] = e_mov(9, 1);
        img[4] = e_st(1, 16'h8B);
        img[5] = e_st(12, 16'h8A);
        img[6] = E_HALT;
        run_prog("R8");
    endtask

    initial begin
        t_forwarding();
        t_loads();
        t_branches();
        t_store_alias();
        t_noops();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule